// File: doc/BRIEF.md
# Circular Instruction Trace Recorder

This block keeps a running history of retired instructions in a ring of 256 entries, each 128 bits wide. Whenever tracing is switched on and the pipeline signals that an instruction has retired, one entry is written at the current write position and the position moves forward by one. After position 255 it returns to 0, so the newest records always replace the oldest. Recording is purely passive: the block has no path back into the pipeline and can never hold it up.

Each entry is four 32-bit words. It holds the instruction address, a flag pair (memory access, trap), the opcode or the memory address, the result, memory data or trap code, and the value of a free-running 30-bit cycle counter. A debug-side port switches tracing on and off, reads and overwrites the write position, and reads any stored word by entry index and word index. Reads return one cycle after the request. A read can be issued in the same cycle as a capture, and both are served.

Top module: `itrace_ring`

## Requirements
- R1: After reset `dbg_on` is 0, `dbg_wptr` is 0 and `dbg_rd_valid` is 0.
- R2: When `ret_valid` is high on a clock edge while tracing is on, the entry at `dbg_wptr` is written and `dbg_wptr` rises by one after that edge. When tracing is off, `ret_valid` writes nothing and `dbg_wptr` keeps its value.
- R3: Following a capture at position 255 the write position is 0, and the next capture overwrites entry 0.
- R4: Word 0 of a non-memory entry is the opcode. Word 1 is `{pc[31:2], trap, is_mem}`, with the trap flag at bit 1 and the memory flag at bit 0.
- R5: For a memory instruction (`ret_is_mem`=1, `ret_trap`=0), word 0 is the load/store address and word 2 the load/store data. For other instructions without a trap, word 2 is the result.
- R6: For a trapped instruction, word 2 is `{24'b0, trap_type}` whatever `ret_is_mem` says. The trap setting takes precedence over the memory data.
- R7: Word 3 is `{2'b00, tag}`. `tag` is a 30-bit counter that is 0 during reset and goes up by one on every clock edge after reset, wrapping modulo 2^30. The stored tag is its value just before the capturing edge.
- R8: A request (`dbg_rd_req`=1) with index `dbg_rd_idx` and word select `dbg_rd_sel` (0 to 3) gives `dbg_rd_valid`=1 in the next cycle, with that word on `dbg_rd_data`. Without a request, `dbg_rd_valid` is 0.
- R9: If a capture and a read of the same entry happen at the same edge, the read returns the newly captured contents.
- R10: `dbg_ptr_we` loads `dbg_ptr_wdata` into the write position after the edge. A capture in that same cycle still goes to the old position, and the loaded value wins over the increment.
- R11: `dbg_ctl_we` loads `dbg_ctl_on` into `dbg_on` after the edge. A capture in that same cycle follows the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_valid | input | 1 | One instruction retires this cycle |
| ret_pc | input | 32 | Address of the retiring instruction |
| ret_opcode | input | 32 | Opcode of the retiring instruction |
| ret_result | input | 32 | Result value |
| ret_is_mem | input | 1 | Instruction is a load or store |
| ret_mem_addr | input | 32 | Load/store address |
| ret_mem_data | input | 32 | Load/store data |
| ret_trap | input | 1 | Instruction trapped |
| ret_trap_type | input | 8 | Trap code |
| dbg_ctl_we | input | 1 | Write the tracing on/off setting |
| dbg_ctl_on | input | 1 | New on/off value |
| dbg_on | output | 1 | Tracing currently on |
| dbg_ptr_we | input | 1 | Overwrite the write position |
| dbg_ptr_wdata | input | 8 | New write position |
| dbg_wptr | output | 8 | Current write position |
| dbg_rd_req | input | 1 | Read request |
| dbg_rd_idx | input | 8 | Entry index to read |
| dbg_rd_sel | input | 2 | Word within the entry |
| dbg_rd_valid | output | 1 | Read data valid |
| dbg_rd_data | output | 32 | Read data word |

## Verification
A capture and a debug read can fall on the same edge. The hard case is when both target the entry at the current write position. The bench provokes this by issuing a read of index `dbg_wptr` in the same cycle as `ret_valid`, for several word selects, and expects the freshly captured words rather than the earlier contents. A second overlap is a pointer overwrite together with a capture. It is judged by reading back the entry at the old position and checking that the new position takes effect.

// File: rtl/itrace_pkg.sv
// Shared constants and entry packing for the instruction trace recorder.
// Assumes a 32-bit instruction address space and a 4-word entry.
package itrace_pkg;
    localparam int WORD_W  = 32;
    localparam int N_WORDS = 4;
    localparam int ENTRY_W = WORD_W * N_WORDS;
    localparam int SEL_W   = $clog2(N_WORDS);

    typedef logic [ENTRY_W-1:0] entry_t;

    // Builds one trace entry; a trap takes precedence over memory data in word 2.
    function automatic entry_t pack_entry(
        input logic [31:0] pc,
        input logic [31:0] opcode,
        input logic [31:0] result,
        input logic        is_mem,
        input logic [31:0] mem_addr,
        input logic [31:0] mem_data,
        input logic        trap,
        input logic [7:0]  trap_type,
        input logic [31:0] tag32
    );
        logic [WORD_W-1:0] w0, w1, w2, w3;
        w0 = is_mem ? mem_addr : opcode;
        w1 = {pc[31:2], trap, is_mem};
        if (trap)        w2 = {24'h0, trap_type};
        else if (is_mem) w2 = mem_data;
        else             w2 = result;
        w3 = tag32;
        return {w3, w2, w1, w0};
    endfunction
endpackage

// File: rtl/itrace_timetag.sv
// Free-running cycle counter used as the time tag of each trace entry.
// Assumes TAG_W <= 32; wraps modulo 2^TAG_W.
module itrace_timetag #(
    parameter int TAG_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [TAG_W-1:0] tag
);
    logic [TAG_W-1:0] tag_q;

    // Count every clock edge outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n) tag_q <= '0;
        else        tag_q <= tag_q + 1'b1;
    end

    assign tag = tag_q;
endmodule

// File: rtl/itrace_ctrl.sv
// Holds the tracing enable and the ring write position.
// Assumes the position wraps naturally at 2^ADDR_W entries.
module itrace_ctrl #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_valid,
    input  logic              ctl_we,
    input  logic              ctl_on,
    input  logic              ptr_we,
    input  logic [ADDR_W-1:0] ptr_wdata,
    output logic              trace_on,
    output logic [ADDR_W-1:0] wptr,
    output logic              cap_fire
);
    logic              on_q;
    logic [ADDR_W-1:0] ptr_q;

    assign cap_fire = ret_valid && on_q;

    // Enable register, loaded only from the debug side.
    always_ff @(posedge clk) begin
        if (!rst_n)      on_q <= 1'b0;
        else if (ctl_we) on_q <= ctl_on;
    end

    // Write position: debug overwrite wins over the capture increment.
    always_ff @(posedge clk) begin
        if (!rst_n)        ptr_q <= '0;
        else if (ptr_we)   ptr_q <= ptr_wdata;
        else if (cap_fire) ptr_q <= ptr_q + 1'b1;
    end

    assign trace_on = on_q;
    assign wptr     = ptr_q;
endmodule

// File: rtl/itrace_store.sv
// Entry storage split into one bank per 32-bit word, one write and one read port.
// Assumes a same-index read and write return the data being written.
module itrace_store
    import itrace_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_idx,
    input  entry_t            wr_entry,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_idx,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    logic [N_WORDS-1:0][WORD_W-1:0] bank_rd;
    logic [SEL_W-1:0]               sel_q;
    logic                           valid_q;
    logic                           hit;

    assign hit = wr_en && (wr_idx == rd_idx);

    for (genvar b = 0; b < N_WORDS; b++) begin : g_bank
        logic [WORD_W-1:0] mem [DEPTH];
        logic [WORD_W-1:0] q;

        // Capture write into this word bank.
        always_ff @(posedge clk) begin
            if (wr_en) mem[wr_idx] <= wr_entry[b*WORD_W +: WORD_W];
        end

        // Registered read with write-first forwarding on an index match.
        always_ff @(posedge clk) begin
            if (rd_req) q <= hit ? wr_entry[b*WORD_W +: WORD_W] : mem[rd_idx];
        end

        assign bank_rd[b] = q;
    end

    // Read valid and word select follow the request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            sel_q   <= '0;
        end else begin
            valid_q <= rd_req;
            if (rd_req) sel_q <= rd_sel;
        end
    end

    assign rd_valid = valid_q;
    assign rd_data  = bank_rd[sel_q];
endmodule

// File: rtl/itrace_ring.sv
// Top of the instruction trace recorder: packs retired-instruction fields with a
// time tag and writes them into a ring under debug control. Never back-pressures.
module itrace_ring
    import itrace_pkg::*;
#(
    parameter  int DEPTH  = 256,
    parameter  int TAG_W  = 30,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_valid,
    input  logic [31:0]       ret_pc,
    input  logic [31:0]       ret_opcode,
    input  logic [31:0]       ret_result,
    input  logic              ret_is_mem,
    input  logic [31:0]       ret_mem_addr,
    input  logic [31:0]       ret_mem_data,
    input  logic              ret_trap,
    input  logic [7:0]        ret_trap_type,
    input  logic              dbg_ctl_we,
    input  logic              dbg_ctl_on,
    output logic              dbg_on,
    input  logic              dbg_ptr_we,
    input  logic [ADDR_W-1:0] dbg_ptr_wdata,
    output logic [ADDR_W-1:0] dbg_wptr,
    input  logic              dbg_rd_req,
    input  logic [ADDR_W-1:0] dbg_rd_idx,
    input  logic [SEL_W-1:0]  dbg_rd_sel,
    output logic              dbg_rd_valid,
    output logic [WORD_W-1:0] dbg_rd_data
);
    logic [TAG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] wptr;
    logic              cap_fire;
    entry_t            entry;

    itrace_timetag #(.TAG_W(TAG_W)) u_tag (
        .clk   (clk),
        .rst_n (rst_n),
        .tag   (tag_q)
    );

    itrace_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ret_valid (ret_valid),
        .ctl_we    (dbg_ctl_we),
        .ctl_on    (dbg_ctl_on),
        .ptr_we    (dbg_ptr_we),
        .ptr_wdata (dbg_ptr_wdata),
        .trace_on  (dbg_on),
        .wptr      (wptr),
        .cap_fire  (cap_fire)
    );

    // Assemble the entry for the instruction retiring this cycle.
    always_comb begin
        entry = pack_entry(ret_pc, ret_opcode, ret_result, ret_is_mem,
                           ret_mem_addr, ret_mem_data, ret_trap, ret_trap_type,
                           32'(tag_q));
    end

    itrace_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cap_fire),
        .wr_idx   (wptr),
        .wr_entry (entry),
        .rd_req   (dbg_rd_req),
        .rd_idx   (dbg_rd_idx),
        .rd_sel   (dbg_rd_sel),
        .rd_valid (dbg_rd_valid),
        .rd_data  (dbg_rd_data)
    );

    assign dbg_wptr = wptr;
endmodule

// File: rtl/itrace_ring_chk.sv
// Protocol checks for itrace_ring, attached through bind. Observes ports and the time tag.
module itrace_ring_chk #(
    parameter int ADDR_W = 8,
    parameter int TAG_W  = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ret_valid,
    input logic              dbg_ctl_we,
    input logic              dbg_ctl_on,
    input logic              dbg_on,
    input logic              dbg_ptr_we,
    input logic [ADDR_W-1:0] dbg_ptr_wdata,
    input logic [ADDR_W-1:0] dbg_wptr,
    input logic              dbg_rd_req,
    input logic              dbg_rd_valid,
    input logic [TAG_W-1:0]  tag_now
);
    // R2
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && dbg_on && !dbg_ptr_we) |=> dbg_wptr == ADDR_W'($past(dbg_wptr) + 1'b1));

    // R2
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ret_valid && dbg_on) && !dbg_ptr_we) |=> $stable(dbg_wptr));

    // R10
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_ptr_we |=> dbg_wptr == $past(dbg_ptr_wdata));

    // R11
    ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_ctl_we |=> dbg_on == $past(dbg_ctl_on));

    // R11
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_ctl_we |=> $stable(dbg_on));

    // R8
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_rd_req |=> dbg_rd_valid);

    // R8
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_rd_req |=> !dbg_rd_valid);

    // R7
    tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tag_now == TAG_W'($past(tag_now) + 1'b1));
endmodule

bind itrace_ring itrace_ring_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ret_valid     (ret_valid),
    .dbg_ctl_we    (dbg_ctl_we),
    .dbg_ctl_on    (dbg_ctl_on),
    .dbg_on        (dbg_on),
    .dbg_ptr_we    (dbg_ptr_we),
    .dbg_ptr_wdata (dbg_ptr_wdata),
    .dbg_wptr      (dbg_wptr),
    .dbg_rd_req    (dbg_rd_req),
    .dbg_rd_valid  (dbg_rd_valid),
    .tag_now       (tag_q)
);

// File: tb/itrace_ring_test.sv
`timescale 1ns/1ps
module itrace_ring_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ret_valid;
    logic [31:0] ret_pc, ret_opcode, ret_result, ret_mem_addr, ret_mem_data;
    logic        ret_is_mem, ret_trap;
    logic [7:0]  ret_trap_type;
    logic        dbg_ctl_we, dbg_ctl_on, dbg_on;
    logic        dbg_ptr_we;
    logic [7:0]  dbg_ptr_wdata, dbg_wptr;
    logic        dbg_rd_req;
    logic [7:0]  dbg_rd_idx;
    logic [1:0]  dbg_rd_sel;
    logic        dbg_rd_valid;
    logic [31:0] dbg_rd_data;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    itrace_ring uut (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
        .ret_opcode(ret_opcode), .ret_result(ret_result), .ret_is_mem(ret_is_mem),
        .ret_mem_addr(ret_mem_addr), .ret_mem_data(ret_mem_data), .ret_trap(ret_trap),
        .ret_trap_type(ret_trap_type), .dbg_ctl_we(dbg_ctl_we), .dbg_ctl_on(dbg_ctl_on),
        .dbg_on(dbg_on), .dbg_ptr_we(dbg_ptr_we), .dbg_ptr_wdata(dbg_ptr_wdata),
        .dbg_wptr(dbg_wptr), .dbg_rd_req(dbg_rd_req), .dbg_rd_idx(dbg_rd_idx),
        .dbg_rd_sel(dbg_rd_sel), .dbg_rd_valid(dbg_rd_valid), .dbg_rd_data(dbg_rd_data)
    );

    // Reference model state
    logic [31:0] m_mem [256][4];
    logic [7:0]  m_ptr = 8'd0;
    logic        m_on  = 1'b0;
    logic [29:0] bc;
    string       cur_req = "R8";
    logic [31:0] q_exp [$];
    string       q_req [$];

    // Bench copy of the time tag: zero in reset, +1 per edge afterwards (R7)
    always @(posedge clk) begin
        if (!rst_n) bc <= '0;
        else        bc <= bc + 1'b1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected entry layout taken from R4..R7
    function automatic logic [127:0] ref_entry(input logic [29:0] tag);
        logic [31:0] w0, w1, w2, w3;
        w0 = ret_is_mem ? ret_mem_addr : ret_opcode;
        w1 = {ret_pc[31:2], ret_trap, ret_is_mem};
        w2 = ret_trap ? {24'h0, ret_trap_type} : (ret_is_mem ? ret_mem_data : ret_result);
        w3 = {2'b00, tag};
        return {w3, w2, w1, w0};
    endfunction

    task automatic idle_inputs();
        ret_valid = 0; dbg_ctl_we = 0; dbg_ptr_we = 0; dbg_rd_req = 0;
    endtask

    // Driver: model this cycle's inputs, queue read expectations, advance one cycle
    task automatic apply();
        logic        cap;
        logic [127:0] e;
        cap = ret_valid && m_on;
        if (cap) begin
            e = ref_entry(bc);
            for (int w = 0; w < 4; w++) m_mem[m_ptr][w] = e[w*32 +: 32];
        end
        if (dbg_rd_req) begin
            q_exp.push_back(m_mem[dbg_rd_idx][dbg_rd_sel]);
            q_req.push_back(cur_req);
        end
        if (dbg_ptr_we) m_ptr = dbg_ptr_wdata;
        else if (cap)   m_ptr = m_ptr + 8'd1;
        if (dbg_ctl_we) m_on = dbg_ctl_on;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic set_cap(input logic [31:0] pc, input logic [31:0] op, input logic [31:0] res,
                           input logic ism, input logic [31:0] ma, input logic [31:0] md,
                           input logic trap, input logic [7:0] tt);
        ret_valid = 1; ret_pc = pc; ret_opcode = op; ret_result = res;
        ret_is_mem = ism; ret_mem_addr = ma; ret_mem_data = md;
        ret_trap = trap; ret_trap_type = tt;
    endtask

    task automatic set_rd(input logic [7:0] idx, input logic [1:0] sel, input string req);
        dbg_rd_req = 1; dbg_rd_idx = idx; dbg_rd_sel = sel; cur_req = req;
    endtask

    // Read all four words of an entry; word 3 is judged against R7
    task automatic read_entry(input logic [7:0] idx, input string req);
        for (int s = 0; s < 4; s++) begin
            set_rd(idx, 2'(s), (s == 3) ? "R7" : req);
            apply();
        end
    endtask

    // Monitor: pops the scoreboard whenever read data is presented
    always @(negedge clk) begin
        if (rst_n === 1'b1 && dbg_rd_valid === 1'b1) begin
            if (q_exp.size() == 0) begin
                n_checks++; n_fails++;
                $display("FAIL R8 actual=unexpected read expected=none");
            end else begin
                chk(q_req.pop_front(), dbg_rd_data, q_exp.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 0; idle_inputs();
        set_cap(0, 0, 0, 0, 0, 0, 0, 0); ret_valid = 0;
        dbg_ctl_on = 0; dbg_ptr_wdata = 0; dbg_rd_idx = 0; dbg_rd_sel = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1", {31'd0, dbg_on}, 32'd0);
        chk("R1", {24'd0, dbg_wptr}, 32'd0);
        chk("R1", {31'd0, dbg_rd_valid}, 32'd0);

        // R2: capture while off is ignored
        set_cap(32'h0000_1000, 32'hDEAD_0001, 32'h1, 0, 0, 0, 0, 0); apply();
        chk("R2", {24'd0, dbg_wptr}, 32'd0);

        // R11: enable; capture in same cycle follows old (off) setting
        dbg_ctl_we = 1; dbg_ctl_on = 1;
        set_cap(32'h0000_1004, 32'hDEAD_0002, 32'h2, 0, 0, 0, 0, 0); apply();
        chk("R11", {31'd0, dbg_on}, 32'd1);
        chk("R11", {24'd0, dbg_wptr}, 32'd0);

        // R4/R5/R6: plain, memory, trap, trap over memory
        set_cap(32'h0000_2000, 32'h8200_4001, 32'h1234_5678, 0, 32'hAAAA_0000, 32'hBBBB_0000, 0, 8'h00); apply();
        set_cap(32'h0000_2004, 32'hC400_0000, 32'h0, 1, 32'h4000_0010, 32'hCAFE_F00D, 0, 8'h00); apply();
        set_cap(32'h0000_2008, 32'h91D0_2000, 32'h5555_5555, 0, 32'h0, 32'h0, 1, 8'h83); apply();
        set_cap(32'h0000_200C, 32'hC200_0000, 32'h6666_6666, 1, 32'h4000_0020, 32'h7777_7777, 1, 8'h09); apply();
        chk("R2", {24'd0, dbg_wptr}, 32'd4);
        read_entry(8'd0, "R4");
        read_entry(8'd1, "R5");
        read_entry(8'd2, "R6");
        read_entry(8'd3, "R6");

        // R9: capture and read of the same entry in the same cycle
        set_cap(32'h0000_3000, 32'h0101_0101, 32'hFACE_0001, 0, 0, 0, 0, 0);
        set_rd(8'd4, 2'd2, "R9"); apply();
        set_cap(32'h0000_3004, 32'h0202_0202, 32'hFACE_0002, 1, 32'h4000_0100, 32'hD00D_0002, 0, 0);
        set_rd(8'd5, 2'd0, "R9"); apply();
        set_cap(32'h0000_3008, 32'h0303_0303, 32'hFACE_0003, 0, 0, 0, 0, 0);
        set_rd(8'd6, 2'd3, "R9"); apply();
        read_entry(8'd4, "R9");

        // R10: pointer load with simultaneous capture at old position 7
        set_cap(32'h0000_4000, 32'h0404_0404, 32'hBEEF_0007, 0, 0, 0, 0, 0);
        dbg_ptr_we = 1; dbg_ptr_wdata = 8'd253; apply();
        chk("R10", {24'd0, dbg_wptr}, 32'd253);
        read_entry(8'd7, "R10");

        // R3: wrap from 255 to 0, overwriting entry 0
        for (int k = 0; k < 4; k++) begin
            set_cap(32'h0000_5000 + 32'(k*4), 32'h0500_0000 + 32'(k), 32'hC0DE_0000 + 32'(k), 0, 0, 0, 0, 0);
            apply();
        end
        chk("R3", {24'd0, dbg_wptr}, 32'd1);
        read_entry(8'd255, "R3");
        read_entry(8'd0, "R3");

        // R2/R11: disable; captures write nothing and pointer holds
        dbg_ctl_we = 1; dbg_ctl_on = 0; apply();
        chk("R11", {31'd0, dbg_on}, 32'd0);
        for (int k = 0; k < 3; k++) begin
            set_cap(32'h0000_6000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0, 0); apply();
        end
        chk("R2", {24'd0, dbg_wptr}, 32'd1);
        read_entry(8'd1, "R2");

        // R8: idle read port stays low
        apply();
        chk("R8", {31'd0, dbg_rd_valid}, 32'd0);

        repeat (3) @(negedge clk);
        chk("R8", 32'(q_exp.size()), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule